// File: doc/BRIEF.md
# Line-Grouped Reorder Buffer

This block tracks in-flight operations in program order, with a whole line as the unit of bookkeeping. Each accepted decode group holds one, two or three operations. It claims one line, and each of its operations sits in a fixed lane of that line. Execution units may finish operations in any order. Each one reports its completion by naming the line index and the lane. Until the owning line retires, every result is still speculative.

Retirement is atomic per line. The oldest allocated line leaves the buffer in the cycle after its last valid lane is reported complete. A lane that was not used at allocation counts as already complete. At most one line leaves per cycle. A synchronous flush discards every line at once.

Top module: `grouped_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `retire_valid` is 0, and `alloc_line` shows line index 0.
- R2: A group with `alloc_valid` and `alloc_ready` both high is accepted at the clock edge. Bit i of `alloc_mask` marks lane i as holding an operation (lanes 0, 1, 2). The group takes the line index shown on `alloc_line`. Successive groups take successive indices, and the index after 23 is 0.
- R3: When all 24 lines are in use, `alloc_ready` is 0 and a presented group is not taken. Once a line retires, allocation resumes at the index that was next before the stall.
- R4: A completion report on a port (valid bit, 5-bit line index, 2-bit lane index) marks that lane done, and reports may arrive in any order. A line with a valid lane that is not done never retires.
- R5: Only the oldest allocated line can retire, and lines retire in allocation order, one per cycle. A younger line that has fully completed waits for every older line.
- R6: Lanes whose mask bit was 0 at allocation count as complete for retirement.
- R7: When the oldest line has every valid lane done, `retire_valid` is 1 in the cycle after the final completion report. That cycle also shows the line index on `retire_line` and the allocation lane mask on `retire_mask`. The line is freed at the following edge.
- R8: While `flush` is high, `retire_valid` and `alloc_ready` are 0. At that edge all lines are discarded: afterwards the buffer is empty, the next group takes index 0, and earlier completion state has no effect.
- R9: A completion report is ignored in any of these cases: it names a line that is not allocated, a line index of 24 or more, a lane whose mask bit is 0, or lane index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all lines at this edge |
| alloc_valid | input | 1 | Decode group presented |
| alloc_mask | input | 3 | Lane occupancy of the group, bit i = lane i |
| alloc_ready | output | 1 | A free line is available |
| alloc_line | output | 5 | Line index the presented group receives |
| cmpl_valid | input | 2 | Completion report valid, one bit per port |
| cmpl_line | input | 10 | Line index per port, port p at bits [5p+4:5p] |
| cmpl_lane | input | 4 | Lane index per port, port p at bits [2p+1:2p] |
| retire_valid | output | 1 | Oldest line retires at this edge |
| retire_line | output | 5 | Index of the retiring line |
| retire_mask | output | 3 | Lane mask of the retiring line |

## Verification
Internal bookkeeping errors become visible at the ports within one or two cycles. A stray done bit makes `retire_valid` rise a cycle early, or on a line that still has an outstanding lane. A pointer that advances wrongly shows up as a repeated or skipped index on `alloc_line` or `retire_line`. A wrong occupancy count shows up as `alloc_ready` holding or dropping at the wrong number of lines. Flush faults appear on the first group after the flush as a wrong index, or as a spurious retirement caused by leftover done state.

// File: rtl/grouped_rob_pkg.sv
package grouped_rob_pkg;

    localparam int ROB_LINES  = 24;
    localparam int ROB_LANES  = 3;
    localparam int CMPL_PORTS = 2;

    typedef logic [ROB_LANES-1:0] lane_mask_t;

    typedef struct packed {
        logic       live;
        lane_mask_t vmask;
        lane_mask_t done;
    } line_state_t;

    // A line is ready to leave when each occupied lane has finished.
    function automatic logic line_finished(line_state_t s);
        return s.live && (&(s.done | ~s.vmask));
    endfunction

    function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import grouped_rob_pkg::*;
#(
    parameter int NUM_LINES = ROB_LINES,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             alloc_fire,
    input  logic             retire_fire,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_fire)
                tail_q <= IDX_W'(wrap_next(int'(tail_q), NUM_LINES));
            if (retire_fire)
                head_q <= IDX_W'(wrap_next(int'(head_q), NUM_LINES));
            case ({alloc_fire, retire_fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign full  = (count_q == CNT_W'(NUM_LINES));
    assign empty = (count_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(NUM_LINES)); // R3
    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_fire); // R3
    AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        empty |-> !retire_fire); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && head == '0 && tail == '0)); // R8

endmodule

// File: rtl/rob_line_array.sv
module rob_line_array
    import grouped_rob_pkg::*;
#(
    parameter int NUM_LINES = ROB_LINES,
    parameter int NUM_CMPL  = CMPL_PORTS,
    localparam int IDX_W  = $clog2(NUM_LINES),
    localparam int LANE_W = $clog2(ROB_LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       alloc_fire,
    input  logic [IDX_W-1:0]           alloc_idx,
    input  lane_mask_t                 alloc_mask,
    input  logic                       retire_fire,
    input  logic [IDX_W-1:0]           retire_idx,
    input  logic [NUM_CMPL-1:0]        cmpl_valid,
    input  logic [NUM_CMPL*IDX_W-1:0]  cmpl_line,
    input  logic [NUM_CMPL*LANE_W-1:0] cmpl_lane,
    output line_state_t [NUM_LINES-1:0] lines
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_t st_q;
        lane_mask_t  hit;

        // Gather completion hits aimed at this line from every port.
        always_comb begin
            hit = '0;
            for (int p = 0; p < NUM_CMPL; p++) begin
                for (int l = 0; l < ROB_LANES; l++) begin
                    if (cmpl_valid[p]
                        && cmpl_line[p*IDX_W +: IDX_W] == IDX_W'(g)
                        && cmpl_lane[p*LANE_W +: LANE_W] == LANE_W'(l))
                        hit[l] = 1'b1;
                end
            end
            if (!st_q.live)
                hit = '0;
            hit = hit & st_q.vmask;
        end

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                st_q <= '0;
            end else if (alloc_fire && alloc_idx == IDX_W'(g)) begin
                st_q.live  <= 1'b1;
                st_q.vmask <= alloc_mask;
                st_q.done  <= '0;
            end else if (retire_fire && retire_idx == IDX_W'(g)) begin
                st_q <= '0;
            end else begin
                st_q.done <= st_q.done | hit;
            end
        end

        assign lines[g] = st_q;

        AST_DONE_WITHIN_MASK: assert property (@(posedge clk) disable iff (rst)
            (st_q.done & ~st_q.vmask) == '0); // R9
        AST_IDLE_LINE_CLEAN: assert property (@(posedge clk) disable iff (rst)
            !st_q.live |-> (st_q.done == '0)); // R9
        AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (st_q.live && !flush && !(retire_fire && retire_idx == IDX_W'(g)))
            |=> ((st_q.done & $past(st_q.done)) == $past(st_q.done))); // R4
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import grouped_rob_pkg::*;
#(
    parameter int NUM_LINES = ROB_LINES,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  line_state_t [NUM_LINES-1:0] lines,
    input  logic [IDX_W-1:0]            head,
    input  logic                        empty,
    input  logic                        flush,
    output logic                        retire_fire,
    output logic [IDX_W-1:0]            retire_idx,
    output lane_mask_t                  retire_mask
);

    line_state_t head_st;

    always_comb begin
        head_st = '0;
        for (int i = 0; i < NUM_LINES; i++)
            if (head == IDX_W'(i))
                head_st = lines[i];
    end

    assign retire_fire = !flush && !empty && line_finished(head_st);
    assign retire_idx  = head;
    assign retire_mask = head_st.vmask;

    AST_HEAD_LIVE: assert property (@(posedge clk) disable iff (rst)
        !empty |-> head_st.live); // R5
    AST_RETIRE_ALL_DONE: assert property (@(posedge clk) disable iff (rst)
        retire_fire |-> ((head_st.vmask & ~head_st.done) == '0)); // R4

endmodule

// File: rtl/grouped_rob.sv
module grouped_rob
    import grouped_rob_pkg::*;
#(
    parameter int NUM_LINES = ROB_LINES,
    parameter int NUM_CMPL  = CMPL_PORTS,
    localparam int IDX_W  = $clog2(NUM_LINES),
    localparam int LANE_W = $clog2(ROB_LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       alloc_valid,
    input  logic [ROB_LANES-1:0]       alloc_mask,
    output logic                       alloc_ready,
    output logic [IDX_W-1:0]           alloc_line,
    input  logic [NUM_CMPL-1:0]        cmpl_valid,
    input  logic [NUM_CMPL*IDX_W-1:0]  cmpl_line,
    input  logic [NUM_CMPL*LANE_W-1:0] cmpl_lane,
    output logic                       retire_valid,
    output logic [IDX_W-1:0]           retire_line,
    output logic [ROB_LANES-1:0]       retire_mask
);

    logic                        full, empty, alloc_fire, retire_fire;
    logic [IDX_W-1:0]            head, tail, retire_idx;
    lane_mask_t                  ret_mask;
    line_state_t [NUM_LINES-1:0] lines;

    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_line  = tail;

    rob_ptr_ctrl #(.NUM_LINES(NUM_LINES)) u_ptr (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_fire(alloc_fire), .retire_fire(retire_fire),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rob_line_array #(.NUM_LINES(NUM_LINES), .NUM_CMPL(NUM_CMPL)) u_lines (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_fire(alloc_fire), .alloc_idx(tail), .alloc_mask(alloc_mask),
        .retire_fire(retire_fire), .retire_idx(retire_idx),
        .cmpl_valid(cmpl_valid), .cmpl_line(cmpl_line), .cmpl_lane(cmpl_lane),
        .lines(lines)
    );

    rob_retire_sel #(.NUM_LINES(NUM_LINES)) u_ret (
        .clk(clk), .rst(rst), .lines(lines), .head(head), .empty(empty),
        .flush(flush), .retire_fire(retire_fire), .retire_idx(retire_idx),
        .retire_mask(ret_mask)
    );

    assign retire_valid = retire_fire;
    assign retire_line  = retire_idx;
    assign retire_mask  = ret_mask;

    AST_RETIRE_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && !flush) |=> (!retire_valid
            || retire_line == IDX_W'(wrap_next(int'($past(retire_line)), NUM_LINES)))); // R5
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!retire_valid && !alloc_ready)); // R8
    AST_ALLOC_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> (flush || $past(flush) || alloc_line ==
            IDX_W'(wrap_next(int'($past(alloc_line)), NUM_LINES)))); // R2

endmodule

// File: tb/tb_grouped_rob.sv
`timescale 1ns/1ps
module tb_grouped_rob;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [2:0] alloc_mask = '0;
    logic       alloc_ready;
    logic [4:0] alloc_line;
    logic [1:0] cmpl_valid = '0;
    logic [9:0] cmpl_line = '0;
    logic [3:0] cmpl_lane = '0;
    logic       retire_valid;
    logic [4:0] retire_line;
    logic [2:0] retire_mask;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    grouped_rob dut (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_mask(alloc_mask),
        .alloc_ready(alloc_ready), .alloc_line(alloc_line),
        .cmpl_valid(cmpl_valid), .cmpl_line(cmpl_line), .cmpl_lane(cmpl_lane),
        .retire_valid(retire_valid), .retire_line(retire_line),
        .retire_mask(retire_mask)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [2:0] m, output int idx);
        alloc_valid = 1'b1;
        alloc_mask  = m;
        #0.5;
        idx = int'(alloc_line);
        chk(alloc_ready == 1'b1, "R2 ready", int'(alloc_ready), 1);
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic cmpl1(input int line, input int lane);
        cmpl_valid = 2'b01;
        cmpl_line  = {5'd0, 5'(line)};
        cmpl_lane  = {2'd0, 2'(lane)};
        tick();
        cmpl_valid = '0;
    endtask

    task automatic cmpl2(input int l0, input int n0, input int l1, input int n1);
        cmpl_valid = 2'b11;
        cmpl_line  = {5'(l1), 5'(l0)};
        cmpl_lane  = {2'(n1), 2'(n0)};
        tick();
        cmpl_valid = '0;
    endtask

    task automatic expect_retire(input string req, input int line, input int mask);
        chk(retire_valid == 1'b1, req, int'(retire_valid), 1);
        chk(int'(retire_line) == line, req, int'(retire_line), line);
        chk(int'(retire_mask) == mask, req, int'(retire_mask), mask);
    endtask

    task automatic expect_idle(input string req);
        chk(retire_valid == 1'b0, req, int'(retire_valid), 0);
    endtask

    task automatic t_reset();
        chk(alloc_ready == 1'b1, "R1 ready", int'(alloc_ready), 1);
        chk(retire_valid == 1'b0, "R1 retire", int'(retire_valid), 0);
        chk(alloc_line == 5'd0, "R1 index", int'(alloc_line), 0);
    endtask

    task automatic t_basic();
        int a;
        do_alloc(3'b111, a);
        chk(a == 0, "R2 first index", a, 0);
        cmpl1(0, 2);
        expect_idle("R4 one of three");
        cmpl1(0, 0);
        expect_idle("R4 two of three");
        cmpl1(0, 1);
        expect_retire("R7 full line", 0, 7);
        tick();
        expect_idle("R7 freed");
    endtask

    task automatic t_partial();
        int a;
        do_alloc(3'b010, a);
        chk(a == 1, "R2 next index", a, 1);
        cmpl1(1, 1);
        expect_retire("R6 unused lanes", 1, 2);
        tick();
    endtask

    task automatic t_order();
        int a, b;
        do_alloc(3'b011, a);
        do_alloc(3'b001, b);
        chk(b == 3, "R2 consecutive", b, 3);
        cmpl1(b, 0);
        expect_idle("R5 younger waits");
        cmpl2(a, 1, a, 0);
        expect_retire("R5 older first", a, 3);
        tick();
        expect_retire("R5 younger next", b, 1);
        tick();
        expect_idle("R5 drained");
    endtask

    task automatic t_ignore();
        int a, b;
        do_alloc(3'b001, a);
        cmpl1(a, 1);
        expect_idle("R9 invalid lane");
        cmpl1(a, 3);
        expect_idle("R9 lane three");
        cmpl1(30, 0);
        expect_idle("R9 line out of range");
        cmpl1(5, 0);
        expect_idle("R9 unallocated line");
        cmpl1(a, 0);
        expect_retire("R9 real report", 4, 1);
        tick();
        do_alloc(3'b001, b);
        chk(b == 5, "R2 index", b, 5);
        expect_idle("R9 no stale completion");
        cmpl1(b, 0);
        expect_retire("R4 line five", 5, 1);
        tick();
    endtask

    task automatic t_full_wrap();
        int a;
        for (int i = 0; i < 24; i++) begin
            do_alloc(3'b001, a);
            chk(a == (6 + i) % 24, "R2 wrap index", a, (6 + i) % 24);
        end
        chk(alloc_ready == 1'b0, "R3 full", int'(alloc_ready), 0);
        alloc_valid = 1'b1;
        tick();
        alloc_valid = 1'b0;
        chk(alloc_ready == 1'b0, "R3 still full", int'(alloc_ready), 0);
        cmpl1(6, 0);
        expect_retire("R3 head retires", 6, 1);
        tick();
        chk(alloc_ready == 1'b1, "R3 space", int'(alloc_ready), 1);
        chk(alloc_line == 5'd6, "R3 resume index", int'(alloc_line), 6);
    endtask

    task automatic t_flush();
        int a;
        cmpl1(7, 0);
        expect_retire("R8 pre-flush", 7, 1);
        flush = 1'b1;
        #0.5;
        expect_idle("R8 retire masked");
        chk(alloc_ready == 1'b0, "R8 alloc masked", int'(alloc_ready), 0);
        tick();
        flush = 1'b0;
        #0.5;
        expect_idle("R8 empty");
        chk(alloc_ready == 1'b1, "R8 ready", int'(alloc_ready), 1);
        chk(alloc_line == 5'd0, "R8 index", int'(alloc_line), 0);
        cmpl1(8, 0);
        expect_idle("R8 stale line");
        do_alloc(3'b111, a);
        chk(a == 0, "R8 first after flush", a, 0);
        cmpl1(0, 0);
        expect_idle("R8 no leftover done");
        cmpl2(0, 1, 0, 2);
        expect_retire("R8 new line retires", 0, 7);
        tick();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #0.5;
        t_reset();
        t_basic();
        t_partial();
        t_order();
        t_ignore();
        t_full_wrap();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule